// File: doc/BRIEF.md
# Reduced-Precision Floating-Point Adder

This block adds two 18-bit floating-point words. Each word holds a sign bit, an 8-bit exponent biased by 128, and a 9-bit fraction mantissa. A normalized mantissa lies in [0.5, 1), so its top bit is set. The value of a word is (-1)^sign * 0.mantissa * 2^(exponent-128). The larger-magnitude operand sets the exponent. The other operand is shifted right to align with it, and any bits shifted out are dropped. The block then adds the mantissas if the signs agree, or subtracts them if the signs differ, and renormalizes the result.

To subtract, the user negates one operand by flipping its sign bit. The block does no rounding, treats no special values, and reports no errors. The arithmetic is combinational. A parameter adds an output register, which is enabled by default.

Top module: `lpfp_add`

## Requirements
- R1: An operand whose mantissa top bit (bit 8) is clear counts as zero, whatever its sign and exponent. A zero result is always the all-zeros word. Any nonzero result has mantissa bit 8 set.
- R2: If the signs are equal and the aligned sum stays below 1.0, the result has the common sign, the exponent of the larger operand, and the sum as mantissa.
- R3: If the signs are equal and the aligned sum reaches 1.0 or more, the mantissa is shifted right one bit and the exponent is incremented. The exponent wraps modulo 256 and no overflow is flagged.
- R4: The smaller operand's mantissa is shifted right by the exponent difference. Bits that fall off the low end are discarded, with no rounding.
- R5: If the exponent difference is 9 or more, the result equals the larger operand.
- R6: If the signs differ, the smaller magnitude is subtracted from the larger. The result takes the sign of the larger-magnitude operand. The difference is shifted left until bit 8 is set, and the exponent is decremented once per shift.
- R7: Operands of equal magnitude and opposite sign give the all-zeros word.
- R8: If renormalizing after a subtraction would take the exponent below 0, the result is the all-zeros word.
- R9: Adding a zero operand returns the other operand unchanged. If both operands are zero, the result is zero.
- R10: With OUT_REG=1, the result appears on the output one clock edge after the operands. An active-low reset clears the output to zero.
- R11: Swapping the two operands does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 18 | First operand {sign, exponent[7:0], mantissa[8:0]} |
| op_b | input | 18 | Second operand, same format |
| sum_q | output | 18 | Sum in the same format |

## Verification
The hardest case to reach from the ports is exponent underflow during renormalization. It needs opposite signs, nearly equal magnitudes, and a larger-operand exponent smaller than the number of leading zeros in the difference. Uniform random words almost never produce this. The stimulus therefore draws one class of vectors with exponents in 0..10, adds a partner at an exponent offset of 0 or 1 with the opposite sign, and includes directed near-cancellation pairs at the bottom of the exponent range.

// File: rtl/lpfp_add.sv
module lpfp_add #(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 9,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [EXP_W+MAN_W:0]     op_a,
  input  logic [EXP_W+MAN_W:0]     op_b,
  output logic [EXP_W+MAN_W:0]     sum_q
);
  localparam int W   = 1 + EXP_W + MAN_W;
  localparam int LZW = $clog2(MAN_W + 1);

  logic             za, zb, sa, sb, swap;
  logic [EXP_W-1:0] ea, eb, e_big, e_sml, dexp;
  logic [MAN_W-1:0] ma, mb, m_big, m_sml, aligned, diff;
  logic             s_big, s_sml;
  logic [MAN_W:0]   sum;
  logic [LZW-1:0]   lz;
  logic [W-1:0]     res;

  assign za = ~op_a[MAN_W-1];
  assign zb = ~op_b[MAN_W-1];
  assign sa = op_a[W-1];
  assign sb = op_b[W-1];
  assign ea = za ? '0 : op_a[W-2:MAN_W];
  assign eb = zb ? '0 : op_b[W-2:MAN_W];
  assign ma = za ? '0 : op_a[MAN_W-1:0];
  assign mb = zb ? '0 : op_b[MAN_W-1:0];

  assign swap  = {eb, mb} > {ea, ma};
  assign e_big = swap ? eb : ea;
  assign e_sml = swap ? ea : eb;
  assign m_big = swap ? mb : ma;
  assign m_sml = swap ? ma : mb;
  assign s_big = swap ? sb : sa;
  assign s_sml = swap ? sa : sb;

  assign dexp    = e_big - e_sml;
  assign aligned = (int'(dexp) >= MAN_W) ? '0 : (m_sml >> dexp);
  assign sum     = {1'b0, m_big} + {1'b0, aligned};
  assign diff    = m_big - aligned;

  always_comb begin
    lz = LZW'(MAN_W);
    for (int i = 0; i < MAN_W; i++)
      if (diff[i]) lz = LZW'(MAN_W - 1 - i);
  end

  always_comb begin
    res = '0;
    if (s_big == s_sml) begin
      if (sum[MAN_W])
        res = {s_big, e_big + 1'b1, sum[MAN_W:1]};
      else if (sum[MAN_W-1])
        res = {s_big, e_big, sum[MAN_W-1:0]};
    end else if (diff != '0 && int'(lz) <= int'(e_big)) begin
      res = {s_big, e_big - EXP_W'(lz), MAN_W'(diff << lz)};
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sum_q <= '0;
        else        sum_q <= res;
    end else begin : g_comb
      assign sum_q = res;
    end
  endgenerate

  a_r1_normalized: assert property (@(posedge clk) disable iff (!rst_n)
    (res != '0) |-> res[MAN_W-1]);

  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (!za && op_a == (op_b ^ (W'(1) << (W-1)))) |-> (res == '0));

  a_r9_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (zb && !za) |-> (res == op_a));

  a_r2_same_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (!za && !zb && sa == sb) |-> (res != '0 && res[W-1] == sa));

  a_r6_sign_of_larger: assert property (@(posedge clk) disable iff (!rst_n)
    (!za && !zb && sa != sb && res != '0) |->
      (res[W-1] == ((op_a[W-2:0] > op_b[W-2:0]) ? sa : sb)));
endmodule

// File: tb/test_lpfp_add.sv
module test_lpfp_add;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] op_a = '0, op_b = '0;
  logic [17:0] sum_q;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  lpfp_add i_lpfp_add (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum_q(sum_q));

  function automatic logic [17:0] mk(int s, int e, int m);
    return {s[0], e[7:0], m[8:0]};
  endfunction

  function automatic logic [17:0] model(logic [17:0] a, logic [17:0] b);
    logic [17:0] t;
    int e, m, mb2, d;
    if (!a[8]) a = '0;
    if (!b[8]) b = '0;
    if (b == '0) return a;
    if (a == '0) return b;
    if (b[16:0] > a[16:0]) begin t = a; a = b; b = t; end
    e = int'(a[16:9]);
    d = e - int'(b[16:9]);
    mb2 = (d >= 9) ? 0 : (int'(b[8:0]) >> d);
    if (a[17] == b[17]) begin
      m = int'(a[8:0]) + mb2;
      if (m >= 512) begin m = m >> 1; e = (e + 1) % 256; end
      return mk(int'(a[17]), e, m);
    end
    m = int'(a[8:0]) - mb2;
    if (m == 0) return '0;
    while (m < 256) begin m = m << 1; e = e - 1; end
    if (e < 0) return '0;
    return mk(int'(a[17]), e, m);
  endfunction

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [17:0] a, logic [17:0] b);
    @(negedge clk);
    op_a = a; op_b = b;
    @(posedge clk);
    @(negedge clk);
    check(req, sum_q, model(a, b));
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [17:0] x, y;
    void'($urandom(32'd2024));
    op_a = mk(0, 128, 256); op_b = mk(0, 128, 256);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset", sum_q, '0);
    rst_n = 1'b1;

    apply("R3 carry", mk(0, 128, 256), mk(0, 128, 256));
    check("R3 value", sum_q, mk(0, 129, 256));
    apply("R2 no carry", mk(0, 128, 256), mk(0, 127, 256));
    check("R2 value", sum_q, mk(0, 128, 384));
    apply("R4 truncate", mk(0, 128, 256), mk(0, 126, 257));
    check("R4 value", sum_q, mk(0, 128, 320));
    apply("R5 far", mk(1, 128, 300), mk(1, 119, 511));
    check("R5 value", sum_q, mk(1, 128, 300));
    apply("R6 subtract", mk(0, 130, 256), mk(1, 128, 384));
    check("R6 value", sum_q, mk(0, 129, 320));
    apply("R6 sign", mk(0, 128, 300), mk(1, 128, 400));
    check("R6 sign value", sum_q, mk(1, 126, 400));
    apply("R7 cancel", mk(1, 77, 333), mk(0, 77, 333));
    check("R7 value", sum_q, '0);
    apply("R8 underflow", mk(0, 1, 256), mk(1, 1, 257));
    check("R8 value", sum_q, '0);
    apply("R9 zero", mk(1, 60, 450), '0);
    check("R9 value", sum_q, mk(1, 60, 450));
    apply("R1 fake zero", mk(0, 200, 100), mk(1, 90, 290));
    check("R1 value", sum_q, mk(1, 90, 290));
    apply("R1 both zero", mk(1, 5, 3), mk(1, 9, 0));
    check("R1 zero value", sum_q, '0);
    apply("R3 wrap", mk(0, 255, 511), mk(0, 255, 511));
    check("R3 wrap value", sum_q, mk(0, 0, 511));
    apply("R11 order a", mk(0, 140, 260), mk(1, 137, 500));
    x = sum_q;
    apply("R11 order b", mk(1, 137, 500), mk(0, 140, 260));
    check("R11 swap", sum_q, x);

    for (int k = 0; k < 3000; k++) begin
      int ea, eb;
      if (k % 3 == 0) begin
        ea = int'($urandom_range(0, 10));
        eb = ea + int'($urandom_range(0, 1));
        x = mk(0, ea, 256 + int'($urandom_range(0, 255)));
        y = mk(1, eb, 256 + int'($urandom_range(0, 255)));
        apply("R8 random", x, y);
      end else if (k % 3 == 1) begin
        ea = int'($urandom_range(12, 243));
        eb = ea - 12 + int'($urandom_range(0, 24));
        x = mk(int'($urandom_range(0, 1)), ea, 256 + int'($urandom_range(0, 255)));
        y = mk(int'($urandom_range(0, 1)), eb, 256 + int'($urandom_range(0, 255)));
        apply("R6 random", x, y);
      end else begin
        x = 18'($urandom);
        y = 18'($urandom);
        apply("R2 random", x, y);
        apply("R11 random", y, x);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule